// File: doc/BRIEF.md
# Double-Rate Write Prefetch Assembler

This block sits at the write input of a double-data-rate memory interface. A source-synchronous write strobe moves a 16-bit data bus and two byte-mask bits, one for each byte lane. The block captures a beat on the rising strobe edge and another on the falling edge. No phase shift is added, because the strobe edges are taken to sit at the centre of the data eye. Each rising-edge beat is joined with the falling-edge beat that follows it. Together they form one 32-bit internal word with a 4-bit byte-enable vector.

A write-window enable marks the time in which strobe edges carry real data. A beat pair becomes a word only when both of its edges fall inside that window. If the window closes between the rising and falling edges, the lone rising-edge beat is discarded and a sticky error flag is set. Each finished word crosses into the core clock domain through a toggle handshake. On the core side it appears as a registered word and byte-enable vector, qualified by a one-cycle valid pulse.

Top module: `ddr_wr_assembler`

## Requirements
- R1: While `rst_n` is low, `word_o`, `be_o`, `valid_o` and `err_o` are all zero.
- R2: The beat captured on a rising strobe edge appears in `word_o[15:0]`. The beat captured on the next falling edge appears in `word_o[31:16]`.
- R3: A mask input at 1 disables its byte and a mask input at 0 enables it. `mask_lo` covers bits 7:0 and `mask_hi` covers bits 15:8 of a beat. In the output, `be_o[0]` = not `mask_lo` at the rising edge, `be_o[1]` = not `mask_hi` at the rising edge, `be_o[2]` = not `mask_lo` at the falling edge, and `be_o[3]` = not `mask_hi` at the falling edge. Both masks high gives a fully disabled beat, and mixed settings enable only the unmasked lane.
- R4: Each completed beat pair produces exactly one `valid_o` pulse, one core cycle wide, provided that pairs are at least 40 ns apart.
- R5: A pair is emitted only if `win_en` is high at both its rising and its falling strobe edge. Strobe edges outside the window produce no output. A falling edge with no in-window rising edge before it produces nothing.
- R6: A rising-edge beat captured in the window whose falling edge sees `win_en` low is discarded. It sets `err_o`, and `err_o` stays at 1 until reset.
- R7: `word_o` and `be_o` hold their values in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wstb | input | 1 | Write strobe; beats are taken on both edges |
| win_en | input | 1 | Write-window enable, sampled at each strobe edge |
| wdata | input | 16 | External write data beat |
| mask_lo | input | 1 | Mask for bits 7:0 of the current beat, 1 = blocked |
| mask_hi | input | 1 | Mask for bits 15:8 of the current beat, 1 = blocked |
| word_o | output | 32 | Assembled internal word, core domain |
| be_o | output | 4 | Byte enables of `word_o`, 1 = write |
| valid_o | output | 1 | One-cycle pulse marking a new `word_o` |
| err_o | output | 1 | Sticky flag for a discarded lone rising-edge beat |

## Verification
The window closing and a falling strobe edge can land together, and the level of `win_en` at that edge alone decides between emitting the pair and discarding the beat with an error. The bench provokes this by dropping the window 1 ns after a falling edge, which must give a normal word and no error. It then drops the window 1 ns before a falling edge, which must give no word and a raised sticky flag. Both outcomes are judged against a queue model of the expected words and against the state of `err_o`.

// File: rtl/ddr_wr_assembler.sv
module ddr_wr_assembler #(
  parameter int BEAT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wstb,
  input  logic                  win_en,
  input  logic [BEAT_W-1:0]     wdata,
  input  logic                  mask_lo,
  input  logic                  mask_hi,
  output logic [2*BEAT_W-1:0]   word_o,
  output logic [3:0]            be_o,
  output logic                  valid_o,
  output logic                  err_o
);
  localparam int WORD_W = 2 * BEAT_W;
  localparam int TOP    = SYNC_STAGES;

  logic              rise_ok;
  logic [BEAT_W-1:0] rise_d;
  logic [1:0]        rise_m;
  logic [WORD_W-1:0] hold_w;
  logic [3:0]        hold_be;
  logic              pair_tgl, lone_tgl;
  logic [TOP:0]      pair_s, lone_s;
  logic              pair_seen, lone_seen;

  always_ff @(posedge wstb or negedge rst_n)
    if (!rst_n) begin
      rise_ok <= 1'b0;
      rise_d  <= '0;
      rise_m  <= '0;
    end else begin
      rise_ok <= win_en;
      if (win_en) begin
        rise_d <= wdata;
        rise_m <= {mask_hi, mask_lo};
      end
    end

  always_ff @(negedge wstb or negedge rst_n)
    if (!rst_n) begin
      hold_w   <= '0;
      hold_be  <= '0;
      pair_tgl <= 1'b0;
      lone_tgl <= 1'b0;
    end else if (rise_ok) begin
      if (win_en) begin
        hold_w   <= {wdata, rise_d};
        hold_be  <= ~{mask_hi, mask_lo, rise_m};
        pair_tgl <= ~pair_tgl;
      end else begin
        lone_tgl <= ~lone_tgl;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pair_s <= '0;
      lone_s <= '0;
    end else begin
      pair_s <= {pair_s[TOP-1:0], pair_tgl};
      lone_s <= {lone_s[TOP-1:0], lone_tgl};
    end

  assign pair_seen = pair_s[TOP] ^ pair_s[TOP-1];
  assign lone_seen = lone_s[TOP] ^ lone_s[TOP-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_o  <= '0;
      be_o    <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= pair_seen;
      if (pair_seen) begin
        word_o <= hold_w;
        be_o   <= hold_be;
      end
      if (lone_seen) err_o <= 1'b1;
    end
endmodule

module ddr_wr_assembler_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_o,
  input logic [3:0]        be_o,
  input logic              valid_o,
  input logic              err_o
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o));
  assert_be_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(be_o));
endmodule

bind ddr_wr_assembler ddr_wr_assembler_chk #(.WORD_W(2*BEAT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .be_o(be_o),
  .valid_o(valid_o), .err_o(err_o)
);

// File: tb/ddr_wr_assembler_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_assembler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wstb = 1'b0;
  logic        win_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        mask_lo = 1'b0, mask_hi = 1'b0;
  logic [31:0] word_o;
  logic [3:0]  be_o;
  logic        valid_o, err_o;

  int total = 0, bad = 0, pulses = 0, sent = 0;
  logic [31:0] q_w[$];
  logic [3:0]  q_b[$];

  always #5 clk = ~clk;

  ddr_wr_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .wstb(wstb), .win_en(win_en), .wdata(wdata),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .word_o(word_o), .be_o(be_o),
    .valid_o(valid_o), .err_o(err_o));

  function automatic logic [3:0] exp_be(input logic [1:0] mr, input logic [1:0] mf);
    return {~mf[1], ~mf[0], ~mr[1], ~mr[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && valid_o) begin
    pulses++;
    if (q_w.size() == 0) check(1'b0, "R5 unexpected word", word_o, 32'h0);
    else begin
      logic [31:0] ew;
      logic [3:0]  eb;
      ew = q_w.pop_front();
      eb = q_b.pop_front();
      check(word_o == ew, "R2 word beat order", word_o, ew);
      check(be_o == eb, "R3 byte enables", {28'h0, be_o}, {28'h0, eb});
    end
  end

  task automatic send_pair(input logic [15:0] dr, input logic [1:0] mr,
                           input logic [15:0] df, input logic [1:0] mf,
                           input int half, input bit expect_word);
    wdata = dr; {mask_hi, mask_lo} = mr;
    #(half/2) wstb = 1'b1;
    #(half/2) begin wdata = df; {mask_hi, mask_lo} = mf; end
    #(half/2) wstb = 1'b0;
    if (expect_word) begin
      q_w.push_back({df, dr});
      q_b.push_back(exp_be(mr, mf));
      sent++;
    end
    #(half/2);
  endtask

  task automatic rand_burst(input int n);
    win_en = 1'b1;
    for (int i = 0; i < n; i++)
      send_pair(16'($urandom), 2'($urandom), 16'($urandom), 2'($urandom),
                20 + int'($urandom_range(0, 20)), 1'b1);
    win_en = 1'b0;
    #200;
  endtask

  task automatic drain_check(input string tag);
    #200;
    check(q_w.size() == 0, tag, 32'(q_w.size()), 32'h0);
    check(pulses == sent, tag, 32'(pulses), 32'(sent));
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 1'b0;
    #30;
    check(word_o == 0 && be_o == 0 && !valid_o && !err_o, "R1 reset state",
          {word_o[27:0], be_o}, 32'h0);
    rst_n = 1'b1;
    #30;

    // directed mask patterns
    win_en = 1'b1;
    send_pair(16'h1234, 2'b00, 16'hABCD, 2'b11, 40, 1'b1); // R3 full beat blocked
    send_pair(16'h00FF, 2'b01, 16'hFF00, 2'b10, 40, 1'b1); // R3 mixed lanes
    send_pair(16'hA5A5, 2'b11, 16'h5A5A, 2'b00, 20, 1'b1); // R4 minimum spacing
    win_en = 1'b0;
    drain_check("R4 one pulse per pair");

    rand_burst(40);
    drain_check("R4 random bursts");

    // window closes just after a falling edge: pair kept, no error (R5)
    win_en = 1'b1;
    wdata = 16'h0F0F; {mask_hi, mask_lo} = 2'b00;
    #10 wstb = 1'b1;
    #10 begin wdata = 16'hF0F0; {mask_hi, mask_lo} = 2'b01; end
    #10 wstb = 1'b0;
    #1 win_en = 1'b0;
    q_w.push_back(32'hF0F0_0F0F); q_b.push_back(exp_be(2'b00, 2'b01)); sent++;
    drain_check("R5 late window close");
    check(!err_o, "R6 no error on late close", {31'h0, err_o}, 32'h0);

    // edges entirely outside the window, and a fall without in-window rise (R5)
    send_pair(16'h1111, 2'b00, 16'h2222, 2'b00, 40, 1'b0);
    #20 wstb = 1'b1;
    #20 win_en = 1'b1;
    #20 wstb = 1'b0;
    #20 win_en = 1'b0;
    drain_check("R5 outside window ignored");
    check(!err_o, "R5 no error outside window", {31'h0, err_o}, 32'h0);

    // lone rising beat: window drops 1 ns before the fall (R6)
    win_en = 1'b1;
    wdata = 16'hDEAD;
    #10 wstb = 1'b1;
    #19 win_en = 1'b0;
    #1 wstb = 1'b0;
    drain_check("R6 lone beat discarded");
    check(err_o, "R6 error set", {31'h0, err_o}, 32'h1);

    rand_burst(10);
    drain_check("R6 traffic after error");
    check(err_o, "R6 error sticky", {31'h0, err_o}, 32'h1);

    rst_n = 1'b0;
    #20;
    check(word_o == 0 && be_o == 0 && !valid_o && !err_o, "R1 reset clears",
          {word_o[27:0], be_o}, 32'h0);
    rst_n = 1'b1;
    #20;
    rand_burst(5);
    drain_check("R2 after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule